// File: doc/BRIEF.md
# Two-level clock-loss status block

This block watches twenty-four clock domains for clock loss. It drives a test signal that toggles once every `PERIOD` cycles of the monitor clock. Each domain loops that signal back as an acknowledge. Every acknowledge passes through a two-flop synchronizer. At the last cycle of each period, the block compares each synchronized acknowledge with the test signal. A domain whose acknowledge disagrees sets its sticky status bit.

The status bits sit in three 8-bit group registers, and each group register has its own enable mask. Each group reduces its enabled status bits to one pointer bit in a summary register. A summary mask then gates those pointers onto a single interrupt line. Software reaches all of this through a single-cycle read/write port. Status is cleared by writing 1 to a bit, which takes effect only once that domain's clock is back. A configuration bit can instead make a read clear a whole group register.

Top module: `clkloss_monitor`

## Requirements
- R1: After reset, every status, mask and configuration register reads 0 and `irq` is 0.
- R2: Domain d (`ack_i[d]`) owns bit d%8 of group register d/8. Group registers sit at addresses 1, 2 and 3. The bit is set when, in the last cycle of a test period, the synchronized acknowledge differs from `test_o`.
- R3: Writing 1 to a set status bit clears it only if the most recent period check found that domain healthy. Writing 0 leaves the bit unchanged.
- R4: Address 4 holds configuration bit 3, which enables clear-on-read. While that bit is 1, reading a group register clears all of its bits. While it is 0, reads change nothing.
- R5: Address 0 is the read-only summary register. It returns the OR of (status AND mask) for group 1 in bit 7, group 2 in bit 6 and group 3 in bit 5. Bits 4:0 read 0. Pointer bits are not sticky.
- R6: `irq` is the OR of the summary bits 7:5 ANDed with the summary mask bits 7:5.
- R7: Each mask sits at its status address plus 8 (8, 9, 10, 11). A mask bit of 1 enables propagation and 0 blocks it. The summary mask keeps only bits 7:5, and its other bits read 0.
- R8: If a status bit is set and cleared in the same cycle, it ends set.
- R9: `test_o` toggles exactly once every `PERIOD` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_i | input | 24 | Per-domain acknowledge of the test signal |
| test_o | output | 1 | Toggling test signal sent to every domain |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for clear-on-read) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Masked clock-loss interrupt |

## Verification
The bench builds the block with `PERIOD` = 4. With that setting, a fault shows up in status within a few cycles, so the sweep can visit all 24 domains one at a time. For each domain it walks the full chain: the set condition, the group pointer, the summary mask, the interrupt, a blocked clear, a write of 0 and a permitted clear. The short period also makes the check cycle easy to find from the `test_o` toggles. The bench uses that to place a clearing read on exactly the cycle where a fault is being set.

// File: rtl/clkloss_monitor.sv
module clkloss_monitor #(
  parameter int PERIOD = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] ack_i,
  output logic        test_o,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        irq
);
  localparam int N     = 24;
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CNT_W-1:0] cnt;
  logic [N-1:0] s1, s2, live, stat, mask, clr;
  logic [2:0] tmask, ptr;
  logic coread;

  wire tick = (cnt == CNT_W'(PERIOD - 1));
  wire [N-1:0] mism = s2 ^ {N{test_o}};

  assign ptr = {|(stat[7:0] & mask[7:0]), |(stat[15:8] & mask[15:8]), |(stat[23:16] & mask[23:16])};
  assign irq = |(ptr & tmask);

  always_comb begin
    clr = '0;
    for (int g = 0; g < 3; g++) begin
      if (wr_en && addr == 4'(g + 1)) clr[g*8 +: 8] = wdata & ~live[g*8 +: 8];
      if (rd_en && coread && addr == 4'(g + 1)) clr[g*8 +: 8] = 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; test_o <= 1'b0; s1 <= '0; s2 <= '0; live <= '0; stat <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) test_o <= ~test_o;
      s1 <= ack_i;
      s2 <= s1;
      if (tick) live <= mism;
      stat <= (stat & ~clr) | (tick ? mism : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0; tmask <= '0; coread <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        4'd4:  coread <= wdata[3];
        4'd8:  tmask <= wdata[7:5];
        4'd9:  mask[7:0] <= wdata;
        4'd10: mask[15:8] <= wdata;
        4'd11: mask[23:16] <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      4'd0:  rdata = {ptr, 5'b0};
      4'd1:  rdata = stat[7:0];
      4'd2:  rdata = stat[15:8];
      4'd3:  rdata = stat[23:16];
      4'd4:  rdata = {4'b0, coread, 3'b0};
      4'd8:  rdata = {tmask, 5'b0};
      4'd9:  rdata = mask[7:0];
      4'd10: rdata = mask[15:8];
      4'd11: rdata = mask[23:16];
      default: rdata = 8'h00;
    endcase
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((stat & $past(s2 ^ {N{test_o}})) == $past(s2 ^ {N{test_o}})));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> ((stat & $past(stat)) == $past(stat)));
  p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && coread) |=> (($past(stat & live) & ~stat) == '0));
  p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd0) |-> (rdata[4:0] == 5'b0));
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmask == 3'b0) |-> !irq);
  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (test_o != $past(test_o)));
endmodule

// File: tb/sim_clkloss_monitor.sv
`timescale 1ns/100ps
module sim_clkloss_monitor;
  localparam int P = 4;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata, got;
  logic [23:0] fault = 0;
  logic test_o, irq;
  int vec = 0, bad = 0;

  always #2 clk = ~clk;

  clkloss_monitor #(.PERIOD(P)) u0 (.clk(clk), .rst_n(rst_n), .ack_i({24{test_o}} ^ fault),
    .test_o(test_o), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic settle();
    repeat (3 * P) @(posedge clk);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int g, b, tg;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    foreach (addr_list[k]) begin
      rd(addr_list[k], got); chk("R1", got, 8'h00);
    end
    chk("R1 irq", {7'b0, irq}, 8'h00);
    // R9 toggle count
    tg = 0; prev = test_o;
    for (int c = 0; c < 4 * P; c++) begin
      @(posedge clk); #1 if (test_o != prev) tg++; prev = test_o;
    end
    chk("R9", 8'(tg), 8'd4);
    // R7 mask placement and readback
    wr(8, 8'hFF); rd(8, got); chk("R7", got, 8'hE0);
    for (int m = 0; m < 3; m++) begin
      wr(4'(9 + m), 8'hA5 ^ 8'(m)); rd(4'(9 + m), got); chk("R7", got, 8'hA5 ^ 8'(m));
      wr(4'(9 + m), 8'h00);
    end
    wr(8, 8'h00);
    // sweep over every domain: R2 R3 R5 R6
    for (int i = 0; i < 24; i++) begin
      g = i / 8; b = i % 8;
      fault = 24'(1) << i; settle();
      rd(4'(g + 1), got); chk("R2", got, 8'(1) << b);
      rd(0, got); chk("R5 masked", got, 8'h00);
      wr(4'(9 + g), 8'(1) << b);
      rd(0, got); chk("R5 pointer", got, 8'h80 >> g);
      chk("R6 gated", {7'b0, irq}, 8'h00);
      wr(8, 8'h80 >> g);
      chk("R6 raised", {7'b0, irq}, 8'h01);
      wr(4'(g + 1), 8'(1) << b);
      rd(4'(g + 1), got); chk("R3 blocked", got, 8'(1) << b);
      fault = 0; settle();
      wr(4'(g + 1), 8'h00);
      rd(4'(g + 1), got); chk("R3 write0", got, 8'(1) << b);
      wr(4'(g + 1), 8'(1) << b);
      rd(4'(g + 1), got); chk("R3 cleared", got, 8'h00);
      rd(0, got); chk("R5 not sticky", got, 8'h00);
      chk("R6 dropped", {7'b0, irq}, 8'h00);
      wr(8, 8'h00); wr(4'(9 + g), 8'h00);
    end
    // R4 clear-on-read
    fault = 24'h000300; settle(); fault = 0; settle();
    rd(2, got); chk("R4 off", got, 8'h03);
    rd(2, got); chk("R4 off keeps", got, 8'h03);
    wr(4, 8'h08); rd(4, got); chk("R4 cfg", got, 8'h08);
    rd(2, got); chk("R4 read", got, 8'h03);
    rd(2, got); chk("R4 cleared", got, 8'h00);
    // R8 set beats clearing read in the check cycle
    fault = 24'h010000; settle();
    prev = test_o;
    do begin @(posedge clk); #1; end while (test_o == prev);
    repeat (P - 1) @(posedge clk);
    rd(3, got); chk("R8 before", got, 8'h01);
    @(negedge clk); addr = 3; #1 chk("R8 set wins", rdata, 8'h01);
    fault = 0; settle();
    rd(3, got); rd(3, got); chk("R4 final", got, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  logic [3:0] addr_list [8] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd8, 4'd9, 4'd11};
endmodule